// File: doc/BRIEF.md
# HDLC Interrupt Status and Mask Unit

This block gathers single-cycle event pulses from an HDLC transmitter and receiver into an 8-bit sticky status register. A processor writes an 8-bit enable mask that has the same bit layout and reads the status back. One active-high interrupt line reports whether any pending status bit is enabled. Reading the status clears every bit. An event that arrives in the same cycle as the read is kept, so no event is lost.

One status bit is shared by two sources, and a select input chooses which one it reports. With the select low, it reports a frame abort received inside a packet. With the select high, it reports a transmitter read of an empty TX FIFO. A received abort only counts once enough bits of the current packet have arrived since the last flag. The block keeps a saturating bit counter for this check, and each received flag clears the counter.

Top module: `hdlc_irq_ctrl`

## Requirements
- R1: Each event pulse sets its status bit on the next clock edge. Status bit positions are: 7 go-ahead, 6 end-of-packet written, 5 transmit end-of-packet, 4 end-of-packet read, 3 TX FIFO low, 2 abort/underrun, 1 RX FIFO full, 0 RX overflow.
- R2: A set status bit stays set until the status register is read.
- R3: A clock edge with `stat_rd_i` high clears every status bit, except bits whose event is present in that same cycle; those bits end up set.
- R4: After reset, the status register and the mask register are all zero and `irq_o` is low.
- R5: A clock edge with `mask_we_i` high loads `mask_wdata_i` into the mask, which is visible on `mask_q_o` after that edge.
- R6: An event whose mask bit is 0 still sets its status bit but does not raise `irq_o`.
- R7: `irq_o` is high exactly when some status bit and the matching mask bit are both 1, without extra register delay.
- R8: With `abort_sel_i` = 0, bit 2 is set only by a qualified received abort, and `tx_underrun_i` has no effect on it.
- R9: With `abort_sel_i` = 1, bit 2 is set only by `tx_underrun_i`, and `rx_abort_i` has no effect on it.
- R10: A received abort qualifies only if at least 26 `rx_bit_i` pulses have been counted since the last `rx_flag_i`, counting the pulses of earlier cycles only.
- R11: `rx_flag_i` restarts the bit count at zero. The count saturates, so an abort after any longer run of bits still qualifies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go_ahead_i | input | 1 | Go-ahead pattern detected |
| eop_wr_i | input | 1 | End-of-packet byte written to the RX FIFO |
| tx_eop_i | input | 1 | Transmitter finished or aborted a packet |
| eop_rd_i | input | 1 | Next RX FIFO byte ends a packet, or the FIFO was read while empty |
| tx_low_i | input | 1 | TX FIFO dropped below its low threshold |
| rx_abort_i | input | 1 | Abort sequence received |
| tx_underrun_i | input | 1 | Transmitter read an empty TX FIFO |
| rx_full_i | input | 1 | RX FIFO rose above its full threshold |
| rx_ovfl_i | input | 1 | Write attempted into a full RX FIFO |
| rx_bit_i | input | 1 | One packet bit received |
| rx_flag_i | input | 1 | Flag received |
| abort_sel_i | input | 1 | Source select for bit 2: 0 abort, 1 underrun |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 8 | Mask write data |
| stat_rd_i | input | 1 | Status read strobe (clears the status) |
| stat_q_o | output | 8 | Current status register |
| mask_q_o | output | 8 | Current mask register |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The bench puts a status read in the same cycle as new events. A design that let the clear win would lose those events. It sends aborts after exactly 25 and exactly 26 counted bits, and after more than a hundred bits. An off-by-one threshold, or a counter that wraps instead of saturating, would set the shared bit at the wrong time or not at all. It switches the source select while both shared sources pulse, which catches a design that reports the wrong source. It also raises masked events, where a design that gated the status bits instead of only the interrupt would lose the record.

// File: rtl/hdlc_irq_pkg.sv
package hdlc_irq_pkg;
   localparam int unsigned STAT_W   = 8;
   localparam int unsigned B_GOAHD  = 7;
   localparam int unsigned B_EOPWR  = 6;
   localparam int unsigned B_TXEOP  = 5;
   localparam int unsigned B_EOPRD  = 4;
   localparam int unsigned B_TXLOW  = 3;
   localparam int unsigned B_ABUND  = 2;
   localparam int unsigned B_RXFULL = 1;
   localparam int unsigned B_RXOVFL = 0;
   typedef logic [STAT_W-1:0] stat_vec_t;
endpackage

// File: rtl/hdlc_abort_qual.sv
module hdlc_abort_qual #(
   parameter int unsigned MIN_BITS = 26
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_bit_i,
   input  logic rx_flag_i,
   input  logic rx_abort_i,
   output logic abort_ok_o
);
   localparam int unsigned CNT_W = (MIN_BITS < 2) ? 1 : $clog2(MIN_BITS + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(MIN_BITS);

   generate
      if (MIN_BITS == 0) begin : g_nocount
         assign abort_ok_o = rx_abort_i;
      end else begin : g_count
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (rx_flag_i)
               cnt_q <= '0;
            else if (rx_bit_i && (cnt_q != CNT_MAX))
               cnt_q <= cnt_q + CNT_W'(1);
         end
         assign abort_ok_o = rx_abort_i && (cnt_q >= CNT_MIN);

         // R11
         flag_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rx_flag_i |=> (cnt_q == '0));
         // R11
         count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_bit_i && !rx_flag_i && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
         // R11
         count_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q == CNT_MAX && !rx_flag_i) |=> (cnt_q == CNT_MAX));
      end
   endgenerate
endmodule

// File: rtl/hdlc_irq_status.sv
module hdlc_irq_status
   import hdlc_irq_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  stat_vec_t evt_i,
   input  logic      rd_i,
   output stat_vec_t stat_o
);
   generate
      for (genvar i = 0; i < STAT_W; i++) begin : g_bit
         logic bit_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               bit_q <= 1'b0;
            else
               bit_q <= evt_i[i] | (bit_q & ~rd_i);
         end
         assign stat_o[i] = bit_q;

         // R1
         evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[i] |=> stat_o[i]);
         // R2
         sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_o[i] && !rd_i) |=> stat_o[i]);
         // R3
         rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_i && !evt_i[i]) |=> !stat_o[i]);
      end
   endgenerate
endmodule

// File: rtl/hdlc_irq_mask.sv
module hdlc_irq_mask
   import hdlc_irq_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      we_i,
   input  stat_vec_t wdata_i,
   output stat_vec_t mask_o
);
   stat_vec_t mask_q;
   always_ff @(posedge clk) begin
      if (!rst_n)
         mask_q <= '0;
      else if (we_i)
         mask_q <= wdata_i;
   end
   assign mask_o = mask_q;

   // R5
   mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> (mask_o == $past(wdata_i)));
   // R5
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> $stable(mask_o));
endmodule

// File: rtl/hdlc_irq_ctrl.sv
module hdlc_irq_ctrl
   import hdlc_irq_pkg::*;
#(
   parameter int unsigned ABORT_MIN_BITS = 26
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go_ahead_i,
   input  logic       eop_wr_i,
   input  logic       tx_eop_i,
   input  logic       eop_rd_i,
   input  logic       tx_low_i,
   input  logic       rx_abort_i,
   input  logic       tx_underrun_i,
   input  logic       rx_full_i,
   input  logic       rx_ovfl_i,
   input  logic       rx_bit_i,
   input  logic       rx_flag_i,
   input  logic       abort_sel_i,
   input  logic       mask_we_i,
   input  logic [7:0] mask_wdata_i,
   input  logic       stat_rd_i,
   output logic [7:0] stat_q_o,
   output logic [7:0] mask_q_o,
   output logic       irq_o
);
   generate
      if (STAT_W != 8) begin : g_bad_width
         $error("status width must be 8");
      end
      if (ABORT_MIN_BITS > 4096) begin : g_bad_min
         $error("abort minimum out of range");
      end
   endgenerate

   logic      abort_ok;
   stat_vec_t evt;
   stat_vec_t stat;
   stat_vec_t mask;

   hdlc_abort_qual #(.MIN_BITS(ABORT_MIN_BITS)) u_qual (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_bit_i   (rx_bit_i),
      .rx_flag_i  (rx_flag_i),
      .rx_abort_i (rx_abort_i),
      .abort_ok_o (abort_ok)
   );

   always_comb begin
      evt           = '0;
      evt[B_GOAHD]  = go_ahead_i;
      evt[B_EOPWR]  = eop_wr_i;
      evt[B_TXEOP]  = tx_eop_i;
      evt[B_EOPRD]  = eop_rd_i;
      evt[B_TXLOW]  = tx_low_i;
      evt[B_ABUND]  = abort_sel_i ? tx_underrun_i : abort_ok;
      evt[B_RXFULL] = rx_full_i;
      evt[B_RXOVFL] = rx_ovfl_i;
   end

   hdlc_irq_status u_stat (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt_i  (evt),
      .rd_i   (stat_rd_i),
      .stat_o (stat)
   );

   hdlc_irq_mask u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (mask_we_i),
      .wdata_i (mask_wdata_i),
      .mask_o  (mask)
   );

   assign stat_q_o = stat;
   assign mask_q_o = mask;
   assign irq_o    = |(stat & mask);

   // R8
   sel_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_q_o[B_ABUND] && !abort_sel_i && !rx_abort_i) |=> !stat_q_o[B_ABUND]);
   // R9
   sel_under_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_q_o[B_ABUND] && abort_sel_i && !tx_underrun_i) |=> !stat_q_o[B_ABUND]);
   // R6
   masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q_o == '0 && !mask_we_i) |=> !irq_o);
endmodule

// File: tb/sim_hdlc_irq_ctrl.sv
module sim_hdlc_irq_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic go_ahead_i = 0, eop_wr_i = 0, tx_eop_i = 0, eop_rd_i = 0, tx_low_i = 0;
   logic rx_abort_i = 0, tx_underrun_i = 0, rx_full_i = 0, rx_ovfl_i = 0;
   logic rx_bit_i = 0, rx_flag_i = 0, abort_sel_i = 0, mask_we_i = 0, stat_rd_i = 0;
   logic [7:0] mask_wdata_i = '0;
   logic [7:0] stat_q_o, mask_q_o;
   logic irq_o;

   int n_chk = 0;
   int n_fail = 0;
   string cur_req = "R4";
   bit done = 0;

   int ref_stat = 0;
   int ref_mask = 0;
   int ref_cnt  = 0;

   always #10 clk = ~clk;

   hdlc_irq_ctrl u0 (.*);

   task automatic chk(input int act, input int exp, input string req, input string what);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // reference model
   always @(posedge clk) begin
      int ev;
      int ab;
      if (!rst_n) begin
         ref_stat = 0; ref_mask = 0; ref_cnt = 0;
      end else begin
         ab = (rx_abort_i && ref_cnt >= 26) ? 1 : 0;
         ev = (go_ahead_i << 7) | (eop_wr_i << 6) | (tx_eop_i << 5) | (eop_rd_i << 4)
            | (tx_low_i << 3) | ((abort_sel_i ? int'(tx_underrun_i) : ab) << 2)
            | (rx_full_i << 1) | int'(rx_ovfl_i);
         ref_stat = stat_rd_i ? ev : (ref_stat | ev);
         if (mask_we_i) ref_mask = mask_wdata_i;
         if (rx_flag_i) ref_cnt = 0;
         else if (rx_bit_i && ref_cnt < 1000) ref_cnt++;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(stat_q_o, ref_stat, cur_req, "status vs model");
         chk(mask_q_o, ref_mask, cur_req, "mask vs model");
         chk(irq_o, ((ref_stat & ref_mask) != 0) ? 1 : 0, cur_req, "irq vs model");
      end
   end

   task automatic cyc();
      @(posedge clk); #2;
   endtask

   task automatic clr();
      {go_ahead_i, eop_wr_i, tx_eop_i, eop_rd_i, tx_low_i, rx_abort_i, tx_underrun_i,
       rx_full_i, rx_ovfl_i, rx_bit_i, rx_flag_i, mask_we_i, stat_rd_i} = '0;
   endtask

   task automatic rd_clear();
      stat_rd_i = 1; cyc(); clr();
   endtask

   task automatic feed_bits(input int n);
      for (int k = 0; k < n; k++) begin rx_bit_i = 1; cyc(); end
      rx_bit_i = 0;
   endtask

   task automatic send_abort_after(input int n);
      rx_flag_i = 1; cyc(); clr();
      feed_bits(n);
      rx_abort_i = 1; cyc(); clr();
   endtask

   initial begin
      #4000000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1;
      cyc();
      // R4 reset state
      chk(stat_q_o, 0, "R4", "status after reset");
      chk(mask_q_o, 0, "R4", "mask after reset");
      chk(irq_o, 0, "R4", "irq after reset");

      // R1 / R6: each event with mask cleared
      cur_req = "R1";
      go_ahead_i = 1; cyc(); clr();
      chk(stat_q_o, 8'h80, "R1", "go-ahead bit 7");
      chk(irq_o, 0, "R6", "masked event no irq");
      rx_ovfl_i = 1; cyc(); clr();
      chk(stat_q_o, 8'h81, "R2", "bits stay set");
      tx_low_i = 1; eop_rd_i = 1; cyc(); clr();
      chk(stat_q_o, 8'h99, "R1", "bits 4 and 3");
      eop_wr_i = 1; tx_eop_i = 1; rx_full_i = 1; cyc(); clr();
      chk(stat_q_o, 8'hFB, "R1", "bits 6,5,1");
      chk(irq_o, 0, "R6", "all masked");

      // R5 / R7
      cur_req = "R5";
      mask_we_i = 1; mask_wdata_i = 8'h04; cyc(); clr();
      chk(mask_q_o, 8'h04, "R5", "mask loaded");
      chk(irq_o, 0, "R7", "only unset bit enabled");
      mask_we_i = 1; mask_wdata_i = 8'h40; cyc(); clr();
      chk(irq_o, 1, "R7", "enabled pending bit");
      cur_req = "R3";
      rd_clear();
      chk(stat_q_o, 0, "R3", "read clears");
      chk(irq_o, 0, "R7", "irq drops after read");

      // R3 same-cycle event during read
      rx_full_i = 1; cyc(); clr();
      stat_rd_i = 1; eop_wr_i = 1; cyc(); clr();
      chk(stat_q_o, 8'h40, "R3", "event kept over read");
      chk(irq_o, 1, "R7", "kept event raises irq");
      rd_clear();

      // R10 abort threshold
      cur_req = "R10";
      abort_sel_i = 0;
      send_abort_after(25);
      chk(stat_q_o, 0, "R10", "abort after 25 bits ignored");
      send_abort_after(26);
      chk(stat_q_o, 8'h04, "R10", "abort after 26 bits");
      rd_clear();
      // abort in the cycle of the 26th bit: only 25 counted before
      rx_flag_i = 1; cyc(); clr();
      feed_bits(25);
      rx_bit_i = 1; rx_abort_i = 1; cyc(); clr();
      chk(stat_q_o, 0, "R10", "abort with 26th bit same cycle");

      // R11 flag restart and saturation
      cur_req = "R11";
      feed_bits(10);
      rx_flag_i = 1; cyc(); clr();
      feed_bits(5);
      rx_abort_i = 1; cyc(); clr();
      chk(stat_q_o, 0, "R11", "flag restarts count");
      send_abort_after(120);
      chk(stat_q_o, 8'h04, "R11", "abort after long run");
      rd_clear();

      // R8 / R9 select
      cur_req = "R8";
      abort_sel_i = 0;
      tx_underrun_i = 1; cyc(); clr();
      chk(stat_q_o, 0, "R8", "underrun ignored with sel 0");
      cur_req = "R9";
      abort_sel_i = 1;
      rx_abort_i = 1; cyc(); clr();
      chk(stat_q_o, 0, "R9", "qualified abort ignored with sel 1");
      tx_underrun_i = 1; cyc(); clr();
      chk(stat_q_o, 8'h04, "R9", "underrun with sel 1");
      rd_clear();

      // random phase against model
      cur_req = "R7";
      for (int i = 0; i < 3000; i++) begin
         int r;
         r = $urandom;
         go_ahead_i = r[0] & r[9]; eop_wr_i = r[1] & r[10]; tx_eop_i = r[2] & r[11];
         eop_rd_i = r[3] & r[12]; tx_low_i = r[4] & r[13]; rx_abort_i = r[5] & r[14];
         tx_underrun_i = r[6] & r[15]; rx_full_i = r[7] & r[16]; rx_ovfl_i = r[8] & r[17];
         rx_bit_i = r[18] | r[19]; rx_flag_i = (r[23:20] == 0);
         abort_sel_i = r[24] & r[25] & r[26];
         stat_rd_i = r[27] & r[28];
         mask_we_i = (r[31:29] == 0);
         mask_wdata_i = 8'($urandom);
         cyc();
      end
      clr();
      cyc();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule